// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a multi-cycle processor built as a small microcoded machine instead of a hand-written state machine. A microaddress register selects one word of an internal constant control store. Each word is 20 bits wide and is divided into compact encoded fields. Local decoders expand those fields into the individual datapath strobes and select lines. A two-bit sequencing field picks the next microaddress in one of three ways: step to the next word, return to the fetch word, or jump through an opcode-indexed dispatch table.

The datapath sits outside the block. It supplies the 6-bit opcode of the instruction register and the ALU zero flag, and it consumes the decoded controls. The microprogram carries routines for six instructions: register-register arithmetic, load word, store word, branch on equal, OR-immediate and jump. Any other opcode returns to fetch straight after decode.

Top module: `useq_ctrl`

## Requirements
- R1: While reset is low, the microaddress is 0 and the controls show the fetch word: mem_read=1, ir_write=1, iord=0, pc_write=1, pc_source=00, alu_sel_a=0, alu_sel_b=001, alu_op=00. All other strobes are 0. Reset is asserted asynchronously and released through a two-flop synchronizer, so the first advance happens on the third rising edge after release.
- R2: A word whose sequencing code is "next" (code 00) advances the microaddress by one. Fetch (address 0) is always followed by decode (address 1), and the multi-word routines walk consecutive addresses.
- R3: Decode (address 1) uses sequencing code 10 and dispatches on the opcode as follows: 000000→7, 100011→2, 101011→5, 000100→9, 001101→10, 000010→12. Every other opcode goes to 0.
- R4: The last word of each routine uses sequencing code 01 and returns to address 0. Cycles per instruction, counting fetch: load 5, store 4, register op 4, OR-immediate 4, branch 3, jump 3, unknown opcode 2.
- R5: alu_op follows the encoding 00 add, 01 subtract, 10 function code, 11 OR. The encoding is used as follows: add in fetch, decode and the address words; function code in the register routine; subtract in branch; OR in OR-immediate.
- R6: alu_sel_b follows the encoding 000 rt, 001 constant 4, 010 sign-extended immediate, 011 sign-extended immediate shifted left 2, 100 zero-extended immediate. alu_sel_a is 0 for PC (fetch and decode) and 1 for rs (execute words).
- R7: pc_source follows the encoding 00 ALU result, 01 Target register, 10 jump address. The jump word asserts pc_write with pc_source=10.
- R8: The branch word asserts pc_write_cond with pc_source=01. pc_load equals pc_write OR (pc_write_cond AND alu_zero), so a branch loads the PC only when alu_zero is 1.
- R9: mem_read and mem_write are never both 1. Instruction fetch reads with iord=0. The load word reads with iord=1, and the store word writes with iord=1.
- R10: Register writes decode from one destination field. The register routine writes rd from the ALU (reg_dst=1, mem_to_reg=0). Load writes rt from memory (reg_dst=0, mem_to_reg=1). OR-immediate writes rt from the ALU (reg_dst=0, mem_to_reg=0). target_write is 1 only in decode.
- R11: The opcode input has no effect in any word other than decode. Every output stays as specified whatever opcode is applied there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU zero flag from the datapath |
| upc | output | 4 | Current microaddress |
| alu_op | output | 2 | ALU operation select |
| alu_sel_a | output | 1 | First ALU operand: 0 PC, 1 rs |
| alu_sel_b | output | 3 | Second ALU operand select |
| reg_write | output | 1 | Register file write strobe |
| mem_to_reg | output | 1 | Register write data from memory |
| reg_dst | output | 1 | Destination register: 0 rt, 1 rd |
| target_write | output | 1 | Target register load |
| mem_read | output | 1 | Memory read strobe |
| mem_write | output | 1 | Memory write strobe |
| iord | output | 1 | Memory address: 0 PC, 1 ALU result |
| ir_write | output | 1 | Instruction register load |
| pc_write | output | 1 | Unconditional PC write |
| pc_write_cond | output | 1 | Conditional PC write on zero |
| pc_source | output | 2 | PC source select |
| pc_load | output | 1 | Effective PC load enable |

## Verification
In the branch word, the conditional PC write and the return to fetch fall in the same cycle. The bench therefore runs every opcode twice, once with alu_zero held at 0 and once at 1. It checks that pc_load follows the flag while the microaddress still goes back to 0 on the next edge. The dispatch decision and the target write also share the decode cycle. A full sweep of all 64 opcodes, with unrelated opcodes driven in every other cycle, shows that only the value present in decode steers the next address.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UADDR_W = 4;
  localparam int UDEPTH  = 1 << UADDR_W;
  localparam int OPC_W   = 6;

  localparam logic [1:0] SQ_NEXT  = 2'b00;
  localparam logic [1:0] SQ_FETCH = 2'b01;
  localparam logic [1:0] SQ_DISP  = 2'b10;

  localparam logic [UADDR_W-1:0] UA_FETCH = 4'd0;
  localparam logic [UADDR_W-1:0] UA_DEC   = 4'd1;
  localparam logic [UADDR_W-1:0] UA_LW    = 4'd2;
  localparam logic [UADDR_W-1:0] UA_SW    = 4'd5;
  localparam logic [UADDR_W-1:0] UA_RR    = 4'd7;
  localparam logic [UADDR_W-1:0] UA_BEQ   = 4'd9;
  localparam logic [UADDR_W-1:0] UA_ORI   = 4'd10;
  localparam logic [UADDR_W-1:0] UA_JMP   = 4'd12;

  typedef struct packed {
    logic [1:0] alu_ctl;
    logic       src1;
    logic [2:0] src2;
    logic [3:0] dest;
    logic [2:0] mem;
    logic       mreg;
    logic [3:0] pcw;
    logic [1:0] seq;
  } uword_t;

  localparam int UWORD_W = $bits(uword_t);
endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  logic [UADDR_W-1:0] addr,
  input  logic [OPC_W-1:0]   opcode,
  output uword_t             word,
  output logic [UADDR_W-1:0] disp_addr
);
  function automatic uword_t mk(logic [1:0] a, logic s1, logic [2:0] s2,
                                logic [3:0] d, logic [2:0] m, logic ir,
                                logic [3:0] p, logic [1:0] q);
    uword_t w;
    w.alu_ctl = a; w.src1 = s1; w.src2 = s2; w.dest = d;
    w.mem = m; w.mreg = ir; w.pcw = p; w.seq = q;
    return w;
  endfunction

  always_comb begin
    case (addr)
      4'd0:    word = mk(2'b00, 1'b0, 3'b001, 4'd0, 3'd1, 1'b1, 4'd1, SQ_NEXT);
      4'd1:    word = mk(2'b00, 1'b0, 3'b011, 4'd1, 3'd0, 1'b0, 4'd0, SQ_DISP);
      4'd2:    word = mk(2'b00, 1'b1, 3'b010, 4'd0, 3'd0, 1'b0, 4'd0, SQ_NEXT);
      4'd3:    word = mk(2'b00, 1'b1, 3'b010, 4'd0, 3'd2, 1'b0, 4'd0, SQ_NEXT);
      4'd4:    word = mk(2'b00, 1'b0, 3'b000, 4'd3, 3'd0, 1'b0, 4'd0, SQ_FETCH);
      4'd5:    word = mk(2'b00, 1'b1, 3'b010, 4'd0, 3'd0, 1'b0, 4'd0, SQ_NEXT);
      4'd6:    word = mk(2'b00, 1'b1, 3'b010, 4'd0, 3'd3, 1'b0, 4'd0, SQ_FETCH);
      4'd7:    word = mk(2'b10, 1'b1, 3'b000, 4'd0, 3'd0, 1'b0, 4'd0, SQ_NEXT);
      4'd8:    word = mk(2'b10, 1'b1, 3'b000, 4'd2, 3'd0, 1'b0, 4'd0, SQ_FETCH);
      4'd9:    word = mk(2'b01, 1'b1, 3'b000, 4'd0, 3'd0, 1'b0, 4'd2, SQ_FETCH);
      4'd10:   word = mk(2'b11, 1'b1, 3'b100, 4'd0, 3'd0, 1'b0, 4'd0, SQ_NEXT);
      4'd11:   word = mk(2'b11, 1'b1, 3'b100, 4'd4, 3'd0, 1'b0, 4'd0, SQ_FETCH);
      4'd12:   word = mk(2'b00, 1'b0, 3'b000, 4'd0, 3'd0, 1'b0, 4'd3, SQ_FETCH);
      default: word = mk(2'b00, 1'b0, 3'b000, 4'd0, 3'd0, 1'b0, 4'd0, SQ_FETCH);
    endcase
  end

  always_comb begin
    case (opcode)
      6'b000000: disp_addr = UA_RR;
      6'b100011: disp_addr = UA_LW;
      6'b101011: disp_addr = UA_SW;
      6'b000100: disp_addr = UA_BEQ;
      6'b001101: disp_addr = UA_ORI;
      6'b000010: disp_addr = UA_JMP;
      default:   disp_addr = UA_FETCH;
    endcase
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         seq,
  input  logic [UADDR_W-1:0] disp_addr,
  output logic [UADDR_W-1:0] upc
);
  localparam logic [UADDR_W-1:0] STEP = 1;
  logic [UADDR_W-1:0] upc_nxt;

  always_comb begin
    case (seq)
      SQ_NEXT: upc_nxt = upc + STEP;
      SQ_DISP: upc_nxt = disp_addr;
      default: upc_nxt = UA_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc <= UA_FETCH;
    else        upc <= upc_nxt;
  end
endmodule

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
(
  input  uword_t     word,
  input  logic       alu_zero,
  output logic [1:0] alu_op,
  output logic       alu_sel_a,
  output logic [2:0] alu_sel_b,
  output logic       reg_write,
  output logic       mem_to_reg,
  output logic       reg_dst,
  output logic       target_write,
  output logic       mem_read,
  output logic       mem_write,
  output logic       iord,
  output logic       ir_write,
  output logic       pc_write,
  output logic       pc_write_cond,
  output logic [1:0] pc_source,
  output logic       pc_load
);
  assign alu_op    = word.alu_ctl;
  assign alu_sel_a = word.src1;
  assign alu_sel_b = word.src2;
  assign ir_write  = word.mreg;

  // destination field: 1 target, 2 rd<-ALU, 3 rt<-mem, 4 rt<-ALU
  always_comb begin
    reg_write = 1'b0; mem_to_reg = 1'b0; reg_dst = 1'b0; target_write = 1'b0;
    case (word.dest)
      4'd1: target_write = 1'b1;
      4'd2: begin reg_write = 1'b1; reg_dst = 1'b1; end
      4'd3: begin reg_write = 1'b1; mem_to_reg = 1'b1; end
      4'd4: reg_write = 1'b1;
      default: ;
    endcase
  end

  // memory field: 1 read at PC, 2 read at ALU, 3 write at ALU
  always_comb begin
    mem_read = 1'b0; mem_write = 1'b0; iord = 1'b0;
    case (word.mem)
      3'd1: mem_read = 1'b1;
      3'd2: begin mem_read = 1'b1; iord = 1'b1; end
      3'd3: begin mem_write = 1'b1; iord = 1'b1; end
      default: ;
    endcase
  end

  // PC field: 1 from ALU, 2 conditional from Target, 3 jump address
  always_comb begin
    pc_write = 1'b0; pc_write_cond = 1'b0; pc_source = 2'b00;
    case (word.pcw)
      4'd1: pc_write = 1'b1;
      4'd2: begin pc_write_cond = 1'b1; pc_source = 2'b01; end
      4'd3: begin pc_write = 1'b1; pc_source = 2'b10; end
      default: ;
    endcase
  end

  assign pc_load = pc_write | (pc_write_cond & alu_zero);
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OPC_W-1:0]   opcode,
  input  logic               alu_zero,
  output logic [UADDR_W-1:0] upc,
  output logic [1:0]         alu_op,
  output logic               alu_sel_a,
  output logic [2:0]         alu_sel_b,
  output logic               reg_write,
  output logic               mem_to_reg,
  output logic               reg_dst,
  output logic               target_write,
  output logic               mem_read,
  output logic               mem_write,
  output logic               iord,
  output logic               ir_write,
  output logic               pc_write,
  output logic               pc_write_cond,
  output logic [1:0]         pc_source,
  output logic               pc_load
);
  logic [1:0]         rst_sync;
  logic               rst_int_n;
  uword_t             word;
  logic [UADDR_W-1:0] disp_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  useq_next u_next (
    .clk(clk), .rst_n(rst_int_n), .seq(word.seq),
    .disp_addr(disp_addr), .upc(upc)
  );

  useq_store u_store (
    .addr(upc), .opcode(opcode), .word(word), .disp_addr(disp_addr)
  );

  useq_decode u_dec (
    .word(word), .alu_zero(alu_zero),
    .alu_op(alu_op), .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b),
    .reg_write(reg_write), .mem_to_reg(mem_to_reg), .reg_dst(reg_dst),
    .target_write(target_write), .mem_read(mem_read), .mem_write(mem_write),
    .iord(iord), .ir_write(ir_write), .pc_write(pc_write),
    .pc_write_cond(pc_write_cond), .pc_source(pc_source), .pc_load(pc_load)
  );
endmodule

// File: rtl/useq_checker.sv
module useq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] upc,
  input logic       alu_zero,
  input logic       reg_write,
  input logic       target_write,
  input logic       mem_read,
  input logic       mem_write,
  input logic       iord,
  input logic       ir_write,
  input logic       pc_write,
  input logic       pc_write_cond,
  input logic [1:0] pc_source,
  input logic       pc_load
);
  assert_mem_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_read && mem_write));

  assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 4'd0 && rst_n) |=> (upc == 4'd1 || upc == 4'd0));

  assert_dispatch_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 4'd1) |=> (upc == 4'd0 || upc == 4'd2 || upc == 4'd5 || upc == 4'd7 ||
                       upc == 4'd9 || upc == 4'd10 || upc == 4'd12));

  assert_branch_returns_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_write_cond |=> (upc == 4'd0));

  assert_cond_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_write_cond && !alu_zero) |-> (!pc_load && pc_source == 2'b01));

  assert_fetch_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ir_write |-> (mem_read && !iord && pc_write));

  assert_target_alone_R10: assert property (@(posedge clk) disable iff (!rst_n)
    target_write |-> (!reg_write && upc == 4'd1));
endmodule

bind useq_ctrl useq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .upc(upc), .alu_zero(alu_zero),
  .reg_write(reg_write), .target_write(target_write),
  .mem_read(mem_read), .mem_write(mem_write), .iord(iord),
  .ir_write(ir_write), .pc_write(pc_write), .pc_write_cond(pc_write_cond),
  .pc_source(pc_source), .pc_load(pc_load)
);

// File: tb/sim_useq_ctrl.sv
`timescale 1ns/1ps
module sim_useq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] opcode = 6'd0;
  logic alu_zero = 1'b0;
  logic [3:0] upc;
  logic [1:0] alu_op, pc_source;
  logic [2:0] alu_sel_b;
  logic alu_sel_a, reg_write, mem_to_reg, reg_dst, target_write;
  logic mem_read, mem_write, iord, ir_write, pc_write, pc_write_cond, pc_load;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  useq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero), .upc(upc),
    .alu_op(alu_op), .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b),
    .reg_write(reg_write), .mem_to_reg(mem_to_reg), .reg_dst(reg_dst),
    .target_write(target_write), .mem_read(mem_read), .mem_write(mem_write),
    .iord(iord), .ir_write(ir_write), .pc_write(pc_write),
    .pc_write_cond(pc_write_cond), .pc_source(pc_source), .pc_load(pc_load)
  );

  // {alu_op, sel_a, sel_b, rw, m2r, rdst, tw, mr, mw, iord, ir, pcw, pcc, psrc}
  function automatic logic [17:0] exp_ctl(int a);
    case (a)
      0:  return {2'b00, 1'b0, 3'b001, 4'b0000, 4'b1001, 2'b10, 2'b00};
      1:  return {2'b00, 1'b0, 3'b011, 4'b0001, 4'b0000, 2'b00, 2'b00};
      2:  return {2'b00, 1'b1, 3'b010, 4'b0000, 4'b0000, 2'b00, 2'b00};
      3:  return {2'b00, 1'b1, 3'b010, 4'b0000, 4'b1010, 2'b00, 2'b00};
      4:  return {2'b00, 1'b0, 3'b000, 4'b1100, 4'b0000, 2'b00, 2'b00};
      5:  return {2'b00, 1'b1, 3'b010, 4'b0000, 4'b0000, 2'b00, 2'b00};
      6:  return {2'b00, 1'b1, 3'b010, 4'b0000, 4'b0110, 2'b00, 2'b00};
      7:  return {2'b10, 1'b1, 3'b000, 4'b0000, 4'b0000, 2'b00, 2'b00};
      8:  return {2'b10, 1'b1, 3'b000, 4'b1010, 4'b0000, 2'b00, 2'b00};
      9:  return {2'b01, 1'b1, 3'b000, 4'b0000, 4'b0000, 2'b01, 2'b01};
      10: return {2'b11, 1'b1, 3'b100, 4'b0000, 4'b0000, 2'b00, 2'b00};
      11: return {2'b11, 1'b1, 3'b100, 4'b1000, 4'b0000, 2'b00, 2'b00};
      12: return {2'b00, 1'b0, 3'b000, 4'b0000, 4'b0000, 2'b10, 2'b10};
      default: return '0;
    endcase
  endfunction

  // routine entry and length per opcode (R3, R4)
  function automatic int entry_of(logic [5:0] op);
    case (op)
      6'b000000: return 7;
      6'b100011: return 2;
      6'b101011: return 5;
      6'b000100: return 9;
      6'b001101: return 10;
      6'b000010: return 12;
      default:   return 0;
    endcase
  endfunction

  function automatic int len_of(logic [5:0] op);
    case (op)
      6'b100011: return 5;
      6'b000000, 6'b101011, 6'b001101: return 4;
      6'b000100, 6'b000010: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic logic [17:0] got_ctl();
    return {alu_op, alu_sel_a, alu_sel_b, reg_write, mem_to_reg, reg_dst,
            target_write, mem_read, mem_write, iord, ir_write,
            pc_write, pc_write_cond, pc_source};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_op(logic [5:0] op, logic z);
    int n;
    int a;
    logic [17:0] e;
    n = len_of(op);
    for (int s = 0; s < n; s++) begin
      @(negedge clk);
      opcode = (s == 1) ? op : 6'(op * 5 + s + 3); // R11: junk outside decode
      alu_zero = z;
      #1;
      a = (s == 0) ? 0 : (s == 1) ? 1 : entry_of(op) + s - 2;
      e = exp_ctl(a);
      check("R2/R3/R4 microaddress", 32'(upc), 32'(a));
      check("R5/R6/R7/R10/R11 controls", 32'(got_ctl()), 32'(e));
      check("R8 pc_load", 32'(pc_load), 32'(e[3] | (e[2] & z)));
      check("R9 memory exclusive", 32'(mem_read & mem_write), 32'd0);
    end
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected below 150000", wd);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    opcode = 6'b000100;
    #1;
    check("R1 reset microaddress", 32'(upc), 32'd0);
    check("R1 reset controls", 32'(got_ctl()), 32'(exp_ctl(0)));
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    check("R1 synchronized release holds address 0", 32'(upc), 32'd0);
    for (int z = 0; z < 2; z++)
      for (int o = 0; o < 64; o++)
        run_op(6'(o), z[0]);
    // back-to-back branch with both zero values, then return to fetch
    run_op(6'b000100, 1'b1);
    run_op(6'b000100, 1'b0);
    @(negedge clk);
    #1;
    check("R4 return after branch", 32'(upc), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule